// File: doc/BRIEF.md
# Frame-Clocked Watchdog Timer

This block supervises a processor by counting frame pulses. An 11-bit binary counter advances once for every rising edge of a free-running 8 kHz frame strobe. The most significant stage drives an active-low watchdog line. Software keeps the line high by writing a service key to the block's register write port. The key is recognised from the five low bits of the written byte: bits 3..0 must be 1010 and bit 4 must be 0. Bits 7..5 are ignored. Any other byte is discarded.

If no valid service write arrives within 1024 frame pulses, the line drops low. It stays low for 1024 frames, then returns high when the counter wraps. A block that is never serviced therefore produces a square wave with a period of 2048 frames. A service write made while the line is low clears the counter and releases the line at once.

The frame strobe is asynchronous to the system clock. It is brought in through a synchronizer and an edge detector, so the block keeps working whichever serial timing mode the rest of the device uses, provided the strobe keeps running. The reset input clears the counter synchronously.

Top module: `frame_watchdog`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, the counter is zero and `wd_n` is 1.
- R2: Each rising edge of `frame_in` advances the counter by exactly one. After 1023 edges with no service, `wd_n` is still 1. After the 1024th edge it is 0.
- R3: A write (`wr_en`=1) whose bits [4:0] equal 5'b01010 clears the counter, whatever bits [7:5] hold. From the cycle after the write, `wd_n` is 1 and 1024 further edges are needed to drop it.
- R4: A write of any other byte (bit 4 set, or bits [3:0] not 1010) leaves the counter unchanged.
- R5: Without service, `wd_n` stays 0 from the 1024th through the 2047th edge. The 2048th edge wraps the counter to zero and `wd_n` returns to 1, repeating every 2048 edges.
- R6: A service write while `wd_n` is 0 returns `wd_n` to 1 in the cycle after the write.
- R7: A frame strobe held high for many clock cycles counts as one edge only.
- R8: When a service write and a detected frame edge fall in the same cycle, the clear wins and the counter ends at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; clears the counter |
| frame_in | input | 1 | Asynchronous 8 kHz frame strobe |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| wd_n | output | 1 | Active-low watchdog output |

## Verification
The hardest case to reach from the ports is a service write that lands in the same clock cycle as the internally detected frame edge. That edge lies several synchronizer stages behind the strobe. The bench raises the frame strobe on a falling clock edge and places the write exactly two falling edges later, so the write is sampled on the edge at which the count would advance. It then shows that a further 1023 frames leave the line high, which tells a winning clear apart from a winning increment. The wrap boundary at 2048 frames is reached by driving the full sequence of strobes.

// File: rtl/frame_watchdog_pkg.sv
package frame_watchdog_pkg;

    localparam int CNT_W       = 11;
    localparam int DATA_W      = 8;
    localparam int SYNC_STAGES = 2;

    localparam logic [DATA_W-1:0] KEY_MASK  = 8'h1F;
    localparam logic [DATA_W-1:0] KEY_VALUE = 8'h0A;

    typedef enum logic {
        WD_HEALTHY = 1'b0,
        WD_EXPIRED = 1'b1
    } wd_state_e;

    typedef struct packed {
        logic tick;
        logic service;
    } wd_ctrl_t;

    function automatic logic key_match(input logic [DATA_W-1:0] data);
        return (data & KEY_MASK) == KEY_VALUE;
    endfunction

endpackage

// File: rtl/wdt_frame_sync.sv
module wdt_frame_sync #(
    parameter int STAGES = frame_watchdog_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_async,
    output logic tick
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], frame_async};
            prev  <= chain[STAGES-1];
        end
    end

    assign tick = chain[STAGES-1] & ~prev;

    // R7: a detected edge never lasts two cycles
    p_single_tick_r7: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/wdt_key_decode.sv
module wdt_key_decode
    import frame_watchdog_pkg::*;
(
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              service
);
    always_comb begin
        service = wr_en && key_match(wr_data);
    end
endmodule

// File: rtl/wdt_frame_counter.sv
module wdt_frame_counter
    import frame_watchdog_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic     clk,
    input  logic     rst,
    input  wd_ctrl_t ctrl,
    output logic     msb
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (ctrl.service)
            cnt <= '0;
        else if (ctrl.tick)
            cnt <= cnt + W'(1);
    end

    assign msb = cnt[W-1];

    // R1: counter is zero after reset
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cnt == '0);
    // R3 and R8: service clears, and wins over a coincident tick
    p_service_clear_r3: assert property (@(posedge clk) disable iff (rst)
        ctrl.service |=> cnt == '0);
    // R2: one step per tick
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (ctrl.tick && !ctrl.service) |=> cnt == $past(cnt) + W'(1));
    // R4: nothing else moves the counter
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.tick && !ctrl.service) |=> $stable(cnt));

endmodule

// File: rtl/frame_watchdog.sv
module frame_watchdog
    import frame_watchdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_in,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wd_n
);
    wd_ctrl_t  ctrl;
    logic      msb;
    wd_state_e state;

    wdt_frame_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk         (clk),
        .rst         (rst),
        .frame_async (frame_in),
        .tick        (ctrl.tick)
    );

    wdt_key_decode key_i (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .service (ctrl.service)
    );

    wdt_frame_counter #(.W(CNT_W)) cnt_i (
        .clk  (clk),
        .rst  (rst),
        .ctrl (ctrl),
        .msb  (msb)
    );

    always_comb begin
        state = msb ? WD_EXPIRED : WD_HEALTHY;
        wd_n  = (state == WD_HEALTHY);
    end

    // R5: the line only drops after a frame tick
    p_fall_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(wd_n) |-> $past(ctrl.tick));
    // R6: a service write always leaves the line high
    p_service_high_r6: assert property (@(posedge clk) disable iff (rst)
        ctrl.service |=> wd_n);

endmodule

// File: tb/frame_watchdog_tb_top.sv
module frame_watchdog_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wd_n;
    int         n_tests = 0;
    int         n_fail = 0;
    int         cycles = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    frame_watchdog dut_i (
        .clk(clk), .rst(rst), .frame_in(frame_in),
        .wr_en(wr_en), .wr_data(wr_data), .wd_n(wd_n)
    );

    // {data, expected service}: R3 accepted keys, R4 rejected bytes
    localparam logic [8:0] VEC [8] = '{
        {8'h0A, 1'b1}, {8'hEA, 1'b1}, {8'h2A, 1'b1}, {8'h8A, 1'b1},
        {8'h1A, 1'b0}, {8'h0B, 1'b0}, {8'h00, 1'b0}, {8'hFA, 1'b0}
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: wd_n=%b expected %b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; frame_in = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic frames(input int n);
        for (int i = 0; i < n; i++) begin
            frame_in = 1'b1;
            repeat (3) @(negedge clk);
            frame_in = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic write(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: run hung, cycles=%0d expected < 190000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        check("R1 during reset", wd_n, 1'b1);
        do_reset();
        @(negedge clk);
        check("R1 after reset", wd_n, 1'b1);

        // R2 / R5 full period
        frames(1023);  check("R2 1023 frames", wd_n, 1'b1);
        frames(1);     check("R2 1024 frames", wd_n, 1'b0);
        frames(1023);  check("R5 2047 frames", wd_n, 1'b0);
        frames(1);     check("R5 wrap 2048", wd_n, 1'b1);
        frames(1024);  check("R5 second period", wd_n, 1'b0);

        // R6: service while low
        write(8'h0A);
        check("R6 release", wd_n, 1'b1);
        frames(1023);  check("R6 restart 1023", wd_n, 1'b1);
        frames(1);     check("R6 restart 1024", wd_n, 1'b0);

        // R3 / R4 table
        for (int v = 0; v < 8; v++) begin
            do_reset();
            frames(1000);
            write(VEC[v][8:1]);
            frames(24);
            check(VEC[v][0] ? "R3 key accepted" : "R4 byte ignored",
                  wd_n, VEC[v][0] ? 1'b1 : 1'b0);
        end

        // R7: long-held strobe counts once
        do_reset();
        frames(1022);
        frame_in = 1'b1;
        repeat (50) @(negedge clk);
        frame_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 held strobe once", wd_n, 1'b1);
        frames(1);
        check("R7 next edge expires", wd_n, 1'b0);

        // R8: service coincides with detected edge
        do_reset();
        frames(1000);
        frame_in = 1'b1;
        repeat (2) @(negedge clk);
        write(8'h0A);
        repeat (2) @(negedge clk);
        frame_in = 1'b0;
        repeat (3) @(negedge clk);
        frames(1023);
        check("R8 clear wins", wd_n, 1'b1);
        frames(1);
        check("R8 then expires", wd_n, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule